// File: doc/BRIEF.md
# Serial Two-Wire Memory Slave Command Engine

This block is the bus-facing command engine of a 256-byte serial memory that answers as an I2C slave. It runs on a fast system clock. SCL and SDA are oversampled through a synchroniser and a majority filter before any edge is detected. SDA is driven as an open drain, so the single `sda_oe_o` output pulls the line low when it is high. The engine finds START and STOP conditions and decodes the device byte. It acknowledges, shifts bytes in and out, and keeps the internal word address counter. With these it runs byte and page writes, random reads, current reads and sequential reads against an internal register-file array.

Written bytes are held in a one-page staging buffer. They reach the array only when a STOP ends the write. The engine then raises a one-cycle commit request towards an external write-commit controller. That controller reports its self-timed cycle back on `busy_i`. While `busy_i` is high, no device byte is acknowledged, so a master can poll for the end of the write. A second device-type code selects the write-protect register. For that target the engine only acknowledges the write and flags the commit. A START followed at once by a STOP cancels the command in progress.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset SDA is released, `addr_known_o` is 1, the word address counter is 00h and every array byte reads FFh.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits clocked before any START get no acknowledge.
- R3: The device byte arrives MSB first. Bits 7..4 must be 1010 (memory), or 0110 (protect register, writes only). Bits 3..1 must equal `dev_sel_i[2:0]`. Bit 0 is R/W, with 1 meaning read. On any mismatch SDA stays released during the ninth clock.
- R4: The engine pulls SDA low in the ninth clock after a matching device byte, after the word address, and after every write data byte. Its SDA drive changes only after a falling SCL edge, a START or a STOP.
- R5: Write data reaches the array only at the STOP that closes the write. `commit_o` pulses for exactly one cycle, once per such STOP.
- R6: Within one write, each data byte advances only the low four address bits, and the upper four stay fixed. A 17th byte therefore overwrites the first.
- R7: A random read (device write byte, word address, repeated START, device read byte) returns the byte at that word address.
- R8: Read data goes out MSB first. A low master acknowledge sends the byte at the next address. A high one releases SDA for good until the next START or STOP.
- R9: A current read returns the byte at the last accessed address plus one. Sequential reads wrap from FFh to 00h.
- R10: While `busy_i` is high, no device byte is acknowledged.
- R11: A protect-register write (type 0110, R/W 0) is acknowledged in full. It leaves the array unchanged and raises `commit_prot_o` together with `commit_o`. A protect-register read gets no acknowledge.
- R12: A START directly followed by a STOP aborts the command. Staged write data is discarded and no commit is raised. If the aborted transaction included a read, `addr_known_o` drops to 0 until a word address is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_sel_i | input | 3 | Strap value that device byte bits 3..1 must match |
| busy_i | input | 1 | High while the write-commit controller runs its cycle |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| commit_o | output | 1 | One-cycle request to start a write cycle |
| commit_prot_o | output | 1 | Qualifies `commit_o` as a protect-register write |
| addr_known_o | output | 1 | Low after a read was aborted; the current address is not trusted |

## Verification
On every cycle the assertions check several properties. The SDA drive moves only after a filtered SCL fall, a START or a STOP. A commit is a single-cycle pulse that follows a STOP, and the protect flag never appears without it. An acknowledge is never raised while busy. The engine stays idle until a START, and SDA stays released while waiting out a refused read. Data-level behaviour can only be shown by the bench's bus scenarios: page rollover and overwrite, the address carried into current and sequential reads, the FFh-to-00h wrap, and discarding staged bytes on an abort.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } ee_state_e;

  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_PROT = 4'b0110;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

endpackage

// File: rtl/i2c_mem_filt.sv
module i2c_mem_filt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import i2c_mem_pkg::*;

  logic [1:0] sync_q;
  logic [2:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      hist_q <= 3'b111;
      q_o    <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], d_i};
      hist_q <= {hist_q[1:0], sync_q[1]};
      q_o    <= maj3(hist_q);
    end
  end

endmodule

// File: rtl/i2c_mem_cond.sv
module i2c_mem_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int PAGE_AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          stg_we_i,
  input  logic [AW-1:0] stg_addr_i,
  input  logic [DW-1:0] stg_data_i,
  input  logic          stg_clr_i,
  input  logic          commit_i,
  output logic          staged_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PG    = 1 << PAGE_AW;

  logic [DW-1:0]         mem_q [DEPTH];
  logic [DW-1:0]         pg_d_q [PG];
  logic [PG-1:0]         pg_v_q;
  logic [AW-PAGE_AW-1:0] pg_hi_q;

  assign rd_data_o = mem_q[rd_addr_i];
  assign staged_o  = |pg_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_v_q  <= '0;
      pg_hi_q <= '0;
      for (int j = 0; j < PG; j++) pg_d_q[j] <= '0;
    end else if (stg_clr_i || commit_i) begin
      pg_v_q <= '0;
    end else if (stg_we_i) begin
      pg_hi_q <= stg_addr_i[AW-1:PAGE_AW];
      pg_v_q[stg_addr_i[PAGE_AW-1:0]] <= 1'b1;
      pg_d_q[stg_addr_i[PAGE_AW-1:0]] <= stg_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      for (int j = 0; j < PG; j++)
        if (pg_v_q[j]) mem_q[{pg_hi_q, PAGE_AW'(j)}] <= pg_d_q[j];
    end
  end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int AW      = 8,
  parameter int PAGE_AW = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       busy_i,
  output logic       sda_oe_o,
  output logic       commit_o,
  output logic       commit_prot_o,
  output logic       addr_known_o
);
  import i2c_mem_pkg::*;

  localparam int DW = 8;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_RX = CW'(DW);
  localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);

  logic [1:0] raw_w, filt_w;
  logic       scl_f, sda_f;
  logic       ev_rise, ev_fall, ev_start, ev_stop;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_mem_filt u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w[g]),
      .q_o   (filt_w[g])
    );
  end

  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  i2c_mem_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_f),
    .sda_i  (sda_f),
    .rise_o (ev_rise),
    .fall_o (ev_fall),
    .start_o(ev_start),
    .stop_o (ev_stop)
  );

  ee_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, tx_q;
  logic [AW-1:0] addr_q;
  logic          known_q, rw_q, prot_q, prot_pend_q, rd_touch_q, mack_q;
  logic          oe_q, commit_q, commit_prot_q;

  logic [DW-1:0] rd_data;
  logic          staged, stg_we, abort, commit_now, dev_match;

  assign dev_match = ((sh_q[7:4] == TYPE_MEM) || (sh_q[7:4] == TYPE_PROT && !sh_q[0]))
                   && (sh_q[3:1] == dev_sel_i) && !busy_i;
  assign stg_we     = ev_fall && (state_q == ST_WDATA) && (cnt_q == LAST_RX) && !prot_q;
  // START immediately followed by STOP: nothing clocked since the START
  assign abort      = ev_stop && (state_q == ST_DEV) && (cnt_q == '0);
  assign commit_now = ev_stop && !abort && (staged || prot_pend_q);

  i2c_mem_store #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_data),
    .stg_we_i  (stg_we),
    .stg_addr_i(addr_q),
    .stg_data_i(sh_q),
    .stg_clr_i (abort),
    .commit_i  (commit_now),
    .staged_o  (staged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      sh_q          <= '0;
      tx_q          <= '0;
      addr_q        <= '0;
      known_q       <= 1'b1;
      rw_q          <= 1'b0;
      prot_q        <= 1'b0;
      prot_pend_q   <= 1'b0;
      rd_touch_q    <= 1'b0;
      mack_q        <= 1'b1;
      oe_q          <= 1'b0;
      commit_q      <= 1'b0;
      commit_prot_q <= 1'b0;
    end else begin
      commit_q      <= commit_now;
      commit_prot_q <= commit_now && prot_pend_q;
      if (ev_stop) begin
        state_q     <= ST_IDLE;
        oe_q        <= 1'b0;
        rd_touch_q  <= 1'b0;
        prot_pend_q <= 1'b0;
        if (abort && rd_touch_q) known_q <= 1'b0;
      end else if (ev_start) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (ev_rise) begin
        if ((state_q == ST_DEV || state_q == ST_WADDR || state_q == ST_WDATA)
            && cnt_q != LAST_RX) begin
          sh_q  <= {sh_q[DW-2:0], sda_f};
          cnt_q <= cnt_q + 1'b1;
        end
        if (state_q == ST_RACK) mack_q <= sda_f;
      end else if (ev_fall) begin
        unique case (state_q)
          ST_DEV: if (cnt_q == LAST_RX) begin
            if (dev_match) begin
              oe_q    <= 1'b1;
              state_q <= ST_DEV_ACK;
              rw_q    <= sh_q[0];
              prot_q  <= (sh_q[7:4] == TYPE_PROT);
            end else begin
              state_q <= ST_WAIT;
            end
          end
          ST_DEV_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q       <= rd_data;
              oe_q       <= ~rd_data[DW-1];
              rd_touch_q <= 1'b1;
              state_q    <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADDR;
            end
          end
          ST_WADDR: if (cnt_q == LAST_RX) begin
            oe_q    <= 1'b1;
            state_q <= ST_WADDR_ACK;
            if (!prot_q) begin
              addr_q  <= sh_q;
              known_q <= 1'b1;
            end
          end
          ST_WDATA: if (cnt_q == LAST_RX) begin
            oe_q    <= 1'b1;
            state_q <= ST_WDATA_ACK;
            if (prot_q) prot_pend_q <= 1'b1;
            else addr_q <= {addr_q[AW-1:PAGE_AW], addr_q[PAGE_AW-1:0] + 1'b1};
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (cnt_q == LAST_TX) begin
              oe_q    <= 1'b0;
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_RACK;
            end else begin
              tx_q  <= {tx_q[DW-2:0], 1'b0};
              oe_q  <= ~tx_q[DW-2];
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RACK: begin
            if (!mack_q) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[DW-1];
              cnt_q   <= '0;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o      = oe_q;
  assign commit_o      = commit_q;
  assign commit_prot_o = commit_prot_q;
  assign addr_known_o  = known_q;

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sda_oe_o,
  input logic                   busy_i,
  input logic                   commit_o,
  input logic                   commit_prot_o,
  input logic                   ev_fall,
  input logic                   ev_start,
  input logic                   ev_stop,
  input i2c_mem_pkg::ee_state_e state_q
);
  import i2c_mem_pkg::*;

  // R4
  drive_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> ($past(ev_fall) || $past(ev_start) || $past(ev_stop)));

  // R5
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  // R5
  commit_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(ev_stop));

  // R10
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && $past(state_q) == ST_DEV) |-> !$past(busy_i));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ev_start) |=> state_q == ST_IDLE);

  // R8
  wait_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !sda_oe_o);

  // R11
  prot_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_prot_o |-> commit_o);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sda_oe_o     (sda_oe_o),
  .busy_i       (busy_i),
  .commit_o     (commit_o),
  .commit_prot_o(commit_prot_o),
  .ev_fall      (ev_fall),
  .ev_start     (ev_start),
  .ev_stop      (ev_stop),
  .state_q      (state_q)
);

// File: tb/sim_i2c_mem_slave.sv
`timescale 1ns/1ps
module sim_i2c_mem_slave;
  localparam int HP = 24;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] DW_ = 8'hAA, DR_ = 8'hAB, PW_ = 8'h6A, PR_ = 8'h6B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, commit, commit_prot, known;
  wire  sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_mem_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_sel_i(SEL), .busy_i(busy), .sda_oe_o(sda_oe),
    .commit_o(commit), .commit_prot_o(commit_prot), .addr_known_o(known)
  );

  int total = 0, bad = 0, n_commit = 0, n_prot = 0, exp_commit = 0;
  bit done = 0;
  int    exp_q[$], act_q[$];
  string tag_q[$];

  always @(posedge clk) begin
    if (commit) n_commit <= n_commit + 1;
    if (commit_prot) n_prot <= n_prot + 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      int a, e; string t;
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      total++;
      if (a != e) begin
        bad++;
        $display("FAIL %s act=%0h exp=%0h", t, a, e);
      end
    end
  end

  task automatic push(input string t, input int a, input int e);
    exp_q.push_back(e); tag_q.push_back(t); act_q.push_back(a);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    scl_m = 1'b0; wait_n(HP/2); sda_m = b; wait_n(HP/2);
    scl_m = 1'b1; wait_n(HP);
  endtask

  task automatic rbit(output logic b);
    scl_m = 1'b0; wait_n(HP/2); sda_m = 1'b1; wait_n(HP/2);
    scl_m = 1'b1; wait_n(HP/2); b = sda_bus; wait_n(HP/2);
  endtask

  task automatic bstart();
    scl_m = 1'b0; wait_n(HP/2); sda_m = 1'b1; wait_n(HP/2);
    scl_m = 1'b1; wait_n(HP); sda_m = 1'b0; wait_n(HP);
  endtask

  task automatic bstop();
    scl_m = 1'b0; wait_n(HP/2); sda_m = 1'b0; wait_n(HP/2);
    scl_m = 1'b1; wait_n(HP); sda_m = 1'b1; wait_n(HP);
  endtask

  task automatic babort();
    scl_m = 1'b0; wait_n(HP/2); sda_m = 1'b1; wait_n(HP/2);
    scl_m = 1'b1; wait_n(HP); sda_m = 1'b0; wait_n(HP);
    sda_m = 1'b1; wait_n(HP);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string t);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(a);
    push(t, a, exp_ack);
  endtask

  task automatic recv(input logic [7:0] exp, input logic mack, input string t);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rbit(b);
      d[i] = b;
    end
    wbit(mack);
    push(t, d, exp);
  endtask

  task automatic set_addr(input logic [7:0] a, input string t);
    bstart(); send(DW_, 1'b0, t); send(a, 1'b0, t); bstart(); send(DR_, 1'b0, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(10); rst_n = 1'b1; wait_n(4);
    push("R1 sda released after reset", sda_oe, 0);
    push("R1 address known after reset", known, 1);
    // R1 / R9: current read from counter 00h returns erased value
    bstart(); send(DR_, 1'b0, "R1 dev ack"); recv(8'hFF, 1'b1, "R1 erased data"); bstop();
    // R2: no START, no response
    send(DW_, 1'b1, "R2 no ack without START"); bstop();
    // R3: mismatches
    bstart(); send(8'hA8, 1'b1, "R3 wrong select nack"); bstop();
    bstart(); send(8'hBA, 1'b1, "R3 wrong type nack"); bstop();
    // R4 / R5 byte write
    bstart(); send(DW_, 1'b0, "R4 dev ack"); send(8'h10, 1'b0, "R4 word ack");
    send(8'hA5, 1'b0, "R4 data ack"); bstop(); exp_commit++;
    wait_n(4); push("R5 commit count", n_commit, exp_commit);
    // R7 random read
    set_addr(8'h10, "R7 setup"); recv(8'hA5, 1'b1, "R7 random read"); bstop();
    // R9 current read = last + 1
    bstart(); send(DR_, 1'b0, "R9 dev ack"); recv(8'hFF, 1'b1, "R9 current read 11h"); bstop();
    // R6 page rollover
    bstart(); send(DW_, 1'b0, "R6 dev"); send(8'h2E, 1'b0, "R6 word");
    send(8'h11, 1'b0, "R6 d0"); send(8'h22, 1'b0, "R6 d1"); send(8'h33, 1'b0, "R6 d2");
    bstop(); exp_commit++;
    set_addr(8'h2E, "R8 setup");
    recv(8'h11, 1'b0, "R8 seq 2E"); recv(8'h22, 1'b0, "R8 seq 2F"); recv(8'hFF, 1'b1, "R8 seq 30");
    bstop();
    set_addr(8'h20, "R6 setup"); recv(8'h33, 1'b1, "R6 rollover to 20h"); bstop();
    // R6 17 bytes overwrite first
    bstart(); send(DW_, 1'b0, "R6 dev"); send(8'h40, 1'b0, "R6 word");
    for (int k = 0; k < 17; k++) send(8'h80 + 8'(k), 1'b0, "R6 page data");
    bstop(); exp_commit++;
    set_addr(8'h40, "R6 setup");
    recv(8'h90, 1'b0, "R6 overwrite 40h"); recv(8'h81, 1'b1, "R6 keep 41h"); bstop();
    // R9 wrap FFh -> 00h
    bstart(); send(DW_, 1'b0, "R9 dev"); send(8'h00, 1'b0, "R9 word"); send(8'h5A, 1'b0, "R9 data");
    bstop(); exp_commit++;
    set_addr(8'hFE, "R9 setup");
    recv(8'hFF, 1'b0, "R9 FEh"); recv(8'hFF, 1'b0, "R9 FFh"); recv(8'h5A, 1'b1, "R9 wrap 00h");
    // R8 released after NACK
    begin
      logic b; int lows = 0;
      for (int i = 0; i < 9; i++) begin rbit(b); if (!b) lows++; end
      push("R8 released after nack", lows, 0);
    end
    bstop();
    // R10 busy
    busy = 1'b1;
    bstart(); send(DW_, 1'b1, "R10 busy write nack"); bstop();
    bstart(); send(DR_, 1'b1, "R10 busy read nack"); bstop();
    busy = 1'b0;
    bstart(); send(DW_, 1'b0, "R10 idle ack"); bstop();
    wait_n(4); push("R5 commit count", n_commit, exp_commit);
    // R11 protect register
    bstart(); send(PW_, 1'b0, "R11 dev ack"); send(8'h00, 1'b0, "R11 word ack");
    send(8'h01, 1'b0, "R11 data ack"); bstop(); exp_commit++;
    wait_n(4);
    push("R11 commit count", n_commit, exp_commit);
    push("R11 protect flag", n_prot, 1);
    set_addr(8'h00, "R11 setup"); recv(8'h5A, 1'b1, "R11 array untouched"); bstop();
    bstart(); send(PR_, 1'b1, "R11 protect read nack"); bstop();
    // R12 write abort
    bstart(); send(DW_, 1'b0, "R12 dev"); send(8'h50, 1'b0, "R12 word"); send(8'h77, 1'b0, "R12 data");
    babort(); wait_n(4);
    push("R12 no commit on abort", n_commit, exp_commit);
    set_addr(8'h50, "R12 setup"); recv(8'hFF, 1'b1, "R12 discarded data"); bstop();
    push("R12 known before abort", known, 1);
    // R12 read abort
    bstart(); send(DR_, 1'b0, "R12 dev"); recv(8'hFF, 1'b1, "R12 read 51h"); babort();
    wait_n(4); push("R12 unknown after abort", known, 0);
    set_addr(8'h10, "R12 setup"); recv(8'hA5, 1'b1, "R12 reread"); bstop();
    wait_n(4); push("R12 known after word address", known, 1);
    wait_n(8);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule